// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It drives the memory's clock enable, command strobes, bank address and address bus through the mandatory power-up script, from reset until the device can take normal traffic. It holds the clock enable low through a long stabilisation wait. It then raises the clock enable with a NOP and walks through a fixed list of commands: precharge all, extended mode load enabling the DLL, base mode load with DLL reset, precharge all, two auto refreshes, and a final base mode load without DLL reset. Each command is followed by its own NOP gap.

The programmed burst length and CAS latency come in as plain inputs and are placed into the base mode word. Every delay is a parameter in clock cycles, so a bench can shorten the long ones. When the script is complete and the DLL has had its lock time, `init_done` rises. It stays high until the next reset, and the command outputs then idle at NOP so that the normal access logic can take over.

Top module: `ddr_powerup_seq`

## Requirements
- R1: While reset is asserted, cke is low, cs_n is high (deselect), ras_n, cas_n and we_n are high, ba and addr are zero and init_done is low; as long as cke is low no command is ever selected.
- R2: After reset release, cke stays low for exactly WAIT_CYC cycles and is high from then until the next reset.
- R3: In the first cycle with cke high, the outputs carry a NOP (cs_n 0, ras_n 1, cas_n 1, we_n 1). In the next cycle they carry PRECHARGE ALL (cs_n 0, ras_n 0, cas_n 1, we_n 0, addr bit 10 high, other addr bits zero).
- R4: T_RP cycles after the first precharge, a LOAD MODE REGISTER (cs_n, ras_n, cas_n, we_n all 0) is issued with ba = 2'b01 and addr all zero, which enables the DLL.
- R5: T_MRD cycles later, a LOAD MODE REGISTER is issued with ba = 2'b00, addr[8] = 1 (DLL reset), addr[6:4] = cas_lat, addr[2:0] = burst_len and all other addr bits zero.
- R6: T_MRD cycles later, a second PRECHARGE ALL is issued. T_RP cycles after that comes an AUTO REFRESH (cs_n 0, ras_n 0, cas_n 0, we_n 1), and T_RFC cycles after that a second AUTO REFRESH.
- R7: T_RFC cycles after the second refresh, a LOAD MODE REGISTER is issued with ba = 2'b00, addr[8] = 0 and the same burst length and CAS latency fields as in R5.
- R8: init_done rises in the later of two cycles: T_MRD cycles after the final mode load, or DLL_LOCK cycles after the DLL-reset mode load. It never rises earlier than DLL_LOCK cycles after the DLL-reset mode load.
- R9: In every other cycle with cke high, the outputs carry a NOP with ba and addr zero. Once high, init_done stays high with NOP on the command pins until reset.
- R10: Asserting reset at any point returns the outputs to the R1 state at once, without waiting for a clock edge, and the script restarts from the beginning on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_len | input | 3 | Burst length code placed in mode bits 2:0 |
| cas_lat | input | 3 | CAS latency code placed in mode bits 6:4 |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once the device is ready |

## Verification
The bench compares every output pin in every cycle against a timeline built from the parameters. An off-by-one in any gap counter therefore shows up as a command one cycle early or late, and a wrong bank or mode field shows up as a mismatch on ba or addr. The test parameters make the DLL lock time longer than the rest of the script. A design that raised init_done when the final mode load finishes, ignoring the lock counter, would finish five cycles early. Resets are dropped in mid-script, and the burst and latency codes include all-zero and all-one values. A design with a synchronous reset, or one that fails to restart cleanly or mixes up the mode fields, would be caught by these cases.

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq #(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned WAIT_CYC = 50000,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned T_RFC    = 18,
  parameter int unsigned DLL_LOCK = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        burst_len,
  input  logic [2:0]        cas_lat,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned MAXG = max2(max2(WAIT_CYC, T_RP), max2(T_MRD, T_RFC));
  localparam int unsigned CW   = $clog2(MAXG + 1);
  localparam int unsigned LW   = $clog2(DLL_LOCK + 1);

  typedef enum logic [3:0] {
    ST_WAIT, ST_CKE, ST_PRE1, ST_EMR, ST_MRR,
    ST_PRE2, ST_REF1, ST_REF2, ST_MRF, ST_DONE
  } st_t;

  st_t            state;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  gap;
  logic [LW-1:0]  lock_cnt;
  logic           issue;
  logic           lock_ok;

  always_comb begin
    case (state)
      ST_WAIT:                  gap = CW'(WAIT_CYC);
      ST_CKE:                   gap = CW'(1);
      ST_PRE1, ST_PRE2:         gap = CW'(T_RP);
      ST_REF1, ST_REF2:         gap = CW'(T_RFC);
      default:                  gap = CW'(T_MRD);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAIT;
      cnt   <= '0;
    end else if (state != ST_DONE) begin
      if (cnt == gap - CW'(1)) begin
        state <= st_t'(state + 4'd1);
        cnt   <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign issue = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_cnt <= '0;
    else if (state == ST_MRR && issue)
      lock_cnt <= LW'(1);
    else if (lock_cnt != '0 && lock_cnt < LW'(DLL_LOCK))
      lock_cnt <= lock_cnt + LW'(1);
  end

  assign lock_ok   = (lock_cnt == LW'(DLL_LOCK));
  assign init_done = (state == ST_DONE) && lock_ok;
  assign cke       = (state != ST_WAIT);

  function automatic logic [ADDR_W-1:0] mode_word(logic dll_rst, logic [2:0] bl, logic [2:0] cl);
    logic [ADDR_W-1:0] w;
    w      = '0;
    w[2:0] = bl;
    w[6:4] = cl;
    w[8]   = dll_rst;
    return w;
  endfunction

  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ba    = 2'b00;
    addr  = '0;
    if (state == ST_WAIT) begin
      cs_n = 1'b1;
    end else if (issue) begin
      case (state)
        ST_PRE1, ST_PRE2: begin
          ras_n    = 1'b0;
          we_n     = 1'b0;
          addr[10] = 1'b1;
        end
        ST_REF1, ST_REF2: begin
          ras_n = 1'b0;
          cas_n = 1'b0;
        end
        ST_EMR: begin
          {ras_n, cas_n, we_n} = 3'b000;
          ba = 2'b01;
        end
        ST_MRR: begin
          {ras_n, cas_n, we_n} = 3'b000;
          addr = mode_word(1'b1, burst_len, cas_lat);
        end
        ST_MRF: begin
          {ras_n, cas_n, we_n} = 3'b000;
          addr = mode_word(1'b0, burst_len, cas_lat);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ddr_powerup_seq_chk.sv
module ddr_powerup_seq_chk #(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned DLL_LOCK = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);
  localparam int unsigned LW = $clog2(DLL_LOCK + 1);

  logic          lmr, pre, nop;
  logic          dll_seen;
  logic [LW-1:0] dll_cnt;

  assign lmr = !cs_n && !ras_n && !cas_n && !we_n;
  assign pre = !cs_n && !ras_n && cas_n && !we_n;
  assign nop = !cs_n && ras_n && cas_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_seen <= 1'b0;
      dll_cnt  <= '0;
    end else if (lmr && ba == 2'b00 && addr[8]) begin
      dll_seen <= 1'b1;
      dll_cnt  <= LW'(1);
    end else if (dll_seen && dll_cnt < LW'(DLL_LOCK)) begin
      dll_cnt <= dll_cnt + LW'(1);
    end
  end

  AST_DESELECT_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> cs_n); // R1
  AST_CKE_STICKY:       assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke); // R2
  AST_PRE_ALL_A10:      assert property (@(posedge clk) disable iff (!rst_n) pre |-> addr[10]); // R3
  AST_EMR_ZERO_ADDR:    assert property (@(posedge clk) disable iff (!rst_n) (lmr && ba == 2'b01) |-> addr == '0); // R4
  AST_LMR_BANK:         assert property (@(posedge clk) disable iff (!rst_n) lmr |-> !ba[1]); // R5
  AST_DLL_WAIT:         assert property (@(posedge clk) disable iff (!rst_n) $rose(init_done) |-> (dll_seen && dll_cnt >= LW'(DLL_LOCK))); // R8
  AST_DONE_STICKY:      assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done); // R9
  AST_DONE_NOP:         assert property (@(posedge clk) disable iff (!rst_n) init_done |-> (nop && cke)); // R9
endmodule

bind ddr_powerup_seq ddr_powerup_seq_chk #(.ADDR_W(ADDR_W), .DLL_LOCK(DLL_LOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
);

// File: tb/test_ddr_powerup_seq.sv
module test_ddr_powerup_seq;
  localparam int AW = 13, W = 20, TRP = 3, TMRD = 2, TRFC = 9, DLL = 30;
  localparam int T_PRE1 = W + 1;
  localparam int T_EMR  = T_PRE1 + TRP;
  localparam int T_MR1  = T_EMR + TMRD;
  localparam int T_PRE2 = T_MR1 + TMRD;
  localparam int T_REF1 = T_PRE2 + TRP;
  localparam int T_REF2 = T_REF1 + TRFC;
  localparam int T_MR2  = T_REF2 + TRFC;
  localparam int T_DONE = T_MR2 + TMRD;
  localparam int T_OK   = (T_DONE > T_MR1 + DLL) ? T_DONE : T_MR1 + DLL;

  logic clk = 0, rst_n = 0;
  logic [2:0] burst_len = 0, cas_lat = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [AW-1:0] addr;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ddr_powerup_seq #(.ADDR_W(AW), .WAIT_CYC(W), .T_RP(TRP), .T_MRD(TMRD),
                    .T_RFC(TRFC), .DLL_LOCK(DLL)) i_ddr_powerup_seq (
    .clk(clk), .rst_n(rst_n), .burst_len(burst_len), .cas_lat(cas_lat),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done));

  function automatic logic [AW-1:0] mword(logic d, logic [2:0] bl, logic [2:0] cl);
    logic [AW-1:0] w = '0;
    w[2:0] = bl; w[6:4] = cl; w[8] = d;
    return w;
  endfunction

  // {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done}
  function automatic logic [AW+7:0] expv(int c, logic [2:0] bl, logic [2:0] cl);
    logic k = (c >= W);
    logic [3:0] cmd = k ? 4'b0111 : 4'b1111;
    logic [1:0] b = 2'b00;
    logic [AW-1:0] a = '0;
    if (c == T_PRE1 || c == T_PRE2) begin cmd = 4'b0010; a[10] = 1'b1; end
    else if (c == T_REF1 || c == T_REF2) cmd = 4'b0001;
    else if (c == T_EMR) begin cmd = 4'b0000; b = 2'b01; end
    else if (c == T_MR1) begin cmd = 4'b0000; a = mword(1'b1, bl, cl); end
    else if (c == T_MR2) begin cmd = 4'b0000; a = mword(1'b0, bl, cl); end
    return {k, cmd, b, a, (c >= T_OK)};
  endfunction

  function automatic string tag(int c);
    if (c < W) return "R2";
    if (c == W || c == T_PRE1) return "R3";
    if (c == T_EMR) return "R4";
    if (c == T_MR1) return "R5";
    if (c == T_PRE2 || c == T_REF1 || c == T_REF2) return "R6";
    if (c == T_MR2) return "R7";
    return "R9";
  endfunction

  function automatic logic [AW+7:0] actv();
    return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done};
  endfunction

  task automatic check(string r, logic [AW+7:0] act, logic [AW+7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic run(logic [2:0] bl, logic [2:0] cl, int abort_at);
    @(negedge clk);
    rst_n = 0; burst_len = bl; cas_lat = cl;
    repeat (2) @(negedge clk);
    check("R1 reset state", actv(), expv(0, bl, cl));
    rst_n = 1;
    #1;
    for (int c = 0; c <= T_OK + 8; c++) begin
      logic [AW+7:0] e = expv(c, bl, cl);
      logic [AW+7:0] a = actv();
      if (a[0] !== e[0]) check("R8 init_done timing", a, e);
      else check(tag(c), a, e);
      if (c == abort_at) begin
        rst_n = 0;
        #1;
        check("R10 async reset mid-sequence", actv(), expv(0, bl, cl));
        return;
      end
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    run(3'd0, 3'd0, -1);
    run(3'd7, 3'd7, -1);
    run(3'd2, 3'd5, T_MR1);
    run(3'd1, 3'd3, T_DONE + 1);
    run(3'd6, 3'd2, 3);
    for (int i = 0; i < 6; i++) begin
      logic [2:0] bl = 3'($urandom);
      logic [2:0] cl = 3'($urandom);
      int ab = (i % 2 == 1) ? int'($urandom_range(1, T_OK)) : -1;
      run(bl, cl, ab);
    end
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule